// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line), oversampled by the system clock. It accepts command frames aimed at a four-channel digital potentiometer and turns each frame into a one-cycle request to a separate register bank. That bank holds the wiper and data registers. The block itself holds no potentiometer state.

A frame opens with a START condition and a slave address byte. The address byte carries a fixed device-type nibble and a 4-bit strap address. An instruction byte follows, holding an opcode, a register select and a pot select. The opcode then fixes how the frame goes on. It may take a data byte to write. It may return a register value to the master. It may end at once as a register transfer. Or it may enter an open-ended stepping mode, where every clock pulse moves the chosen wiper one position in the direction given by the data line, until STOP.

Top module: `pot_cmd_slave`

## Requirements
- R1: After START, the first byte (MSB first) is acknowledged by pulling SDA low in the ninth clock only when bits [7:4] equal 4'b0101 and bits [3:0] equal `addr_strap`. On a mismatch there is no acknowledge, and no request is issued until the next START.
- R2: When `bank_busy` is high at the end of the address byte, the address is not acknowledged and the frame issues no request.
- R3: The instruction byte is split as opcode [7:4], register select [3:2] and pot select [1:0]. The valid opcodes are 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010. Any other opcode is not acknowledged and issues no request.
- R4: Opcodes 1010 (write wiper) and 1100 (write data register) take a third byte, which is acknowledged. After that byte, exactly one request is issued: `req_cmd` is 2 or 4 respectively, `req_data` holds the byte, and `req_reg` and `req_pot` come from the instruction.
- R5: Opcodes 1001 (read wiper) and 1011 (read data register) issue one request with `req_cmd` 1 or 3 when the instruction is acknowledged. `rd_data` is captured as the acknowledge clock ends. The slave then drives it MSB first over the next eight clocks and releases SDA after the eighth.
- R6: The transfer opcodes issue one request at the instruction acknowledge and take no data byte. The codes are 1101 to `req_cmd` 5, 1110 to 6, 0001 (global) to 7 and 1000 (global) to 8.
- R7: After opcode 0010 is acknowledged, each complete SCL high pulse issues one request. `req_cmd` is 9 (step up) if SDA was high at the rising edge and 10 (step down) if it was low. The STOP that ends the mode issues no step.
- R8: A START in the middle of a frame abandons it with no request and restarts address matching.
- R9: `req_valid` is a single-cycle pulse. SDA is released after every STOP.
- R10: After reset, `sda_oe` and `req_valid` are low.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_strap | input | 4 | Strap address matched against address bits [3:0] |
| bank_busy | input | 1 | Register bank cannot take a new frame |
| rd_data | input | 8 | Register value returned by the bank for reads |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| req_valid | output | 1 | One-cycle request strobe |
| req_cmd | output | 4 | Request code 1..10 |
| req_reg | output | 2 | Register select from the instruction |
| req_pot | output | 2 | Pot select from the instruction |
| req_data | output | 8 | Write data, zero for other requests |

## Verification
A bit counter that is off by one shows up in the same byte: the acknowledge lands in the wrong clock and the master reads a NACK. A wrong phase after the instruction byte shows as a missing or extra request within one byte time, or as SDA driven in a clock where the master owns it. A step flag left armed shows as one extra step request at STOP. Read data that is shifted or sampled at the wrong moment shows as a wrong value within the eight read clocks.

// File: rtl/pot_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the potentiometer command slave.
// Assumes the request codes below are the contract with the register bank.
package pot_pkg;
    localparam int BYTE_W = 8;
    localparam int CMD_W  = 4;

    localparam logic [CMD_W-1:0] CMD_NONE     = 4'd0;
    localparam logic [CMD_W-1:0] CMD_RD_WCR   = 4'd1;
    localparam logic [CMD_W-1:0] CMD_WR_WCR   = 4'd2;
    localparam logic [CMD_W-1:0] CMD_RD_DR    = 4'd3;
    localparam logic [CMD_W-1:0] CMD_WR_DR    = 4'd4;
    localparam logic [CMD_W-1:0] CMD_DR2WCR   = 4'd5;
    localparam logic [CMD_W-1:0] CMD_WCR2DR   = 4'd6;
    localparam logic [CMD_W-1:0] CMD_G_DR2WCR = 4'd7;
    localparam logic [CMD_W-1:0] CMD_G_WCR2DR = 4'd8;
    localparam logic [CMD_W-1:0] CMD_STEP_UP  = 4'd9;
    localparam logic [CMD_W-1:0] CMD_STEP_DN  = 4'd10;

    typedef enum logic [2:0] {K_BAD, K_READ, K_WRITE, K_XFER, K_STEP} kind_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA, PH_STEP, PH_HOLD
    } phase_e;
endpackage

// File: rtl/pot_line_sync.sv
`timescale 1ns/1ps
// Synchronizes the two bus lines and detects clock edges and START/STOP.
// Assumes STAGES >= 2; lines reset to the idle-high level.
module pot_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop of each synchronizer chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_chain[0] <= 1'b1;
                        sda_chain[0] <= 1'b1;
                    end else begin
                        scl_chain[0] <= scl_in;
                        sda_chain[0] <= sda_in;
                    end
                end
            end else begin : g_next
                // Further flops of each synchronizer chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_chain[g] <= 1'b1;
                        sda_chain[g] <= 1'b1;
                    end else begin
                        scl_chain[g] <= scl_chain[g-1];
                        sda_chain[g] <= sda_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // Previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pot_instr_decode.sv
`timescale 1ns/1ps
// Maps the 4-bit opcode to a frame kind and a request code.
// Purely combinational; unknown opcodes report K_BAD.
module pot_instr_decode
    import pot_pkg::*;
(
    input  logic [3:0]       op,
    output kind_e            kind,
    output logic [CMD_W-1:0] cmd
);
    // Opcode lookup.
    always_comb begin
        kind = K_BAD;
        cmd  = CMD_NONE;
        unique case (op)
            4'b1001: begin kind = K_READ;  cmd = CMD_RD_WCR;   end
            4'b1010: begin kind = K_WRITE; cmd = CMD_WR_WCR;   end
            4'b1011: begin kind = K_READ;  cmd = CMD_RD_DR;    end
            4'b1100: begin kind = K_WRITE; cmd = CMD_WR_DR;    end
            4'b1101: begin kind = K_XFER;  cmd = CMD_DR2WCR;   end
            4'b1110: begin kind = K_XFER;  cmd = CMD_WCR2DR;   end
            4'b0001: begin kind = K_XFER;  cmd = CMD_G_DR2WCR; end
            4'b1000: begin kind = K_XFER;  cmd = CMD_G_WCR2DR; end
            4'b0010: begin kind = K_STEP;  cmd = CMD_NONE;     end
            default: begin kind = K_BAD;   cmd = CMD_NONE;     end
        endcase
    end
endmodule

// File: rtl/pot_frame_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer: shifts bytes in, decides acknowledges, shifts read
// data out, runs the stepping mode and issues register requests.
// Assumes synchronized line events from pot_line_sync.
module pot_frame_ctrl
    import pot_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [3:0]        addr_strap,
    input  logic              bank_busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              req_valid,
    output logic [CMD_W-1:0]  req_cmd,
    output logic [1:0]        req_reg,
    output logic [1:0]        req_pot,
    output logic [BYTE_W-1:0] req_data
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    phase_e            phase, nxt_phase;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] instr_q;
    logic [BYTE_W-2:0] tx;
    logic              in_ack;
    logic              step_dir;
    logic              armed;

    logic [BYTE_W-1:0] dec_in;
    kind_e             kind;
    logic [CMD_W-1:0]  dec_cmd;

    logic              byte_ack;
    phase_e            ack_next;
    logic              issue;
    logic [1:0]        iss_reg;
    logic [1:0]        iss_pot;
    logic [BYTE_W-1:0] iss_data;

    assign dec_in = (phase == PH_INSTR) ? shreg : instr_q;

    pot_instr_decode u_dec (
        .op   (dec_in[7:4]),
        .kind (kind),
        .cmd  (dec_cmd)
    );

    // Byte-end decision: acknowledge, next phase and request contents.
    always_comb begin
        byte_ack = 1'b0;
        ack_next = PH_HOLD;
        issue    = 1'b0;
        iss_reg  = instr_q[3:2];
        iss_pot  = instr_q[1:0];
        iss_data = '0;
        case (phase)
            PH_ADDR: begin
                byte_ack = (shreg[7:4] == DEV_TYPE) && (shreg[3:0] == addr_strap)
                           && !bank_busy;
                ack_next = PH_INSTR;
            end
            PH_INSTR: begin
                byte_ack = (kind != K_BAD);
                iss_reg  = shreg[3:2];
                iss_pot  = shreg[1:0];
                issue    = (kind == K_READ) || (kind == K_XFER);
                case (kind)
                    K_WRITE: ack_next = PH_WDATA;
                    K_READ:  ack_next = PH_RDATA;
                    K_STEP:  ack_next = PH_STEP;
                    default: ack_next = PH_HOLD;
                endcase
            end
            PH_WDATA: begin
                byte_ack = 1'b1;
                ack_next = PH_HOLD;
                issue    = 1'b1;
                iss_data = shreg;
            end
            default: ;
        endcase
    end

    // Main sequencer with START/STOP taking priority over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            nxt_phase <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            instr_q   <= '0;
            tx        <= '0;
            in_ack    <= 1'b0;
            step_dir  <= 1'b0;
            armed     <= 1'b0;
            sda_oe    <= 1'b0;
            req_valid <= 1'b0;
            req_cmd   <= CMD_NONE;
            req_reg   <= '0;
            req_pot   <= '0;
            req_data  <= '0;
        end else begin
            req_valid <= 1'b0;
            if (start_ev || stop_ev) begin
                phase  <= start_ev ? PH_ADDR : PH_IDLE;
                bitcnt <= '0;
                in_ack <= 1'b0;
                armed  <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_INSTR, PH_WDATA: begin
                        if (in_ack) begin
                            if (scl_fall) begin
                                in_ack <= 1'b0;
                                bitcnt <= '0;
                                phase  <= nxt_phase;
                                if (nxt_phase == PH_RDATA) begin
                                    tx     <= rd_data[BYTE_W-2:0];
                                    sda_oe <= ~rd_data[BYTE_W-1];
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end else if (scl_rise && bitcnt < LAST_BIT) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == LAST_BIT) begin
                            if (phase == PH_INSTR) begin
                                instr_q <= shreg;
                            end
                            if (byte_ack) begin
                                in_ack    <= 1'b1;
                                sda_oe    <= 1'b1;
                                nxt_phase <= ack_next;
                                if (issue) begin
                                    req_valid <= 1'b1;
                                    req_cmd   <= dec_cmd;
                                    req_reg   <= iss_reg;
                                    req_pot   <= iss_pot;
                                    req_data  <= iss_data;
                                end
                            end else begin
                                phase <= PH_HOLD;
                            end
                        end
                    end
                    PH_RDATA: begin
                        if (scl_rise && bitcnt < LAST_BIT) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt != 4'd0) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_HOLD;
                            end else begin
                                sda_oe <= ~tx[BYTE_W-2];
                                tx     <= {tx[BYTE_W-3:0], 1'b0};
                            end
                        end
                    end
                    PH_STEP: begin
                        if (scl_rise) begin
                            step_dir <= sda_s;
                            armed    <= 1'b1;
                        end else if (scl_fall && armed) begin
                            armed     <= 1'b0;
                            req_valid <= 1'b1;
                            req_cmd   <= step_dir ? CMD_STEP_UP : CMD_STEP_DN;
                            req_reg   <= instr_q[3:2];
                            req_pot   <= instr_q[1:0];
                            req_data  <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pot_cmd_slave.sv
`timescale 1ns/1ps
// Top of the two-wire potentiometer command slave: line synchronizer
// plus frame sequencer. Assumes an external register bank consumes the
// one-cycle requests and presents rd_data before the read byte starts.
module pot_cmd_slave
    import pot_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic [3:0]  addr_strap,
    input  logic        bank_busy,
    input  logic [7:0]  rd_data,
    output logic        sda_oe,
    output logic        req_valid,
    output logic [3:0]  req_cmd,
    output logic [1:0]  req_reg,
    output logic [1:0]  req_pot,
    output logic [7:0]  req_data
);
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_ev;
    logic stop_ev;

    pot_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    pot_frame_ctrl #(.DEV_TYPE(DEV_TYPE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .addr_strap (addr_strap),
        .bank_busy  (bank_busy),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .req_valid  (req_valid),
        .req_cmd    (req_cmd),
        .req_reg    (req_reg),
        .req_pot    (req_pot),
        .req_data   (req_data)
    );
endmodule

// File: rtl/pot_cmd_slave_sva.sv
`timescale 1ns/1ps
// Property checker for pot_cmd_slave, attached by bind below.
// Watches the line events and the request and drive outputs.
module pot_cmd_slave_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       sda_oe,
    input logic       req_valid,
    input logic [3:0] req_cmd
);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    assert_release_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);

    assert_drive_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    assert_cmd_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_cmd != 4'd0 && req_cmd <= 4'd10));
endmodule

bind pot_cmd_slave pot_cmd_slave_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_oe    (sda_oe),
    .req_valid (req_valid),
    .req_cmd   (req_cmd)
);

// File: tb/pot_cmd_slave_tb.sv
`timescale 1ns/1ps
module pot_cmd_slave_tb;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] strap = 4'h6;
    logic       busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       sda_oe, req_valid;
    logic [3:0] req_cmd;
    logic [1:0] req_reg, req_pot;
    logic [7:0] req_data;
    logic       sda_line;

    int n_chk = 0;
    int n_err = 0;
    int req_cnt = 0;
    int pulse_err = 0;
    int oe_glitch = 0;
    logic [3:0] log_cmd [0:63];
    logic [1:0] log_reg [0:63];
    logic [1:0] log_pot [0:63];
    logic [7:0] log_dat [0:63];
    logic prev_v = 1'b0, prev_oe = 1'b0, prev_scl = 1'b1;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    pot_cmd_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_strap(strap), .bank_busy(busy), .rd_data(rd_data),
        .sda_oe(sda_oe), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_reg(req_reg), .req_pot(req_pot), .req_data(req_data)
    );

    // Request log and line-discipline monitor, sampled after the edges settle.
    always @(negedge clk) begin
        #0.5;
        if (rst_n) begin
            if (req_valid) begin
                if (req_cnt < 64) begin
                    log_cmd[req_cnt] = req_cmd;
                    log_reg[req_cnt] = req_reg;
                    log_pot[req_cnt] = req_pot;
                    log_dat[req_cnt] = req_data;
                end
                req_cnt++;
            end
            if (req_valid && prev_v) pulse_err++;
            if (sda_oe != prev_oe && scl_m && prev_scl) oe_glitch++;
        end
        prev_v   = req_valid;
        prev_oe  = sda_oe;
        prev_scl = scl_m;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = !sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit mack);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q);
            v = {v[6:0], sda_line}; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        send_bit(!mack);
    endtask

    task automatic chk_req(input string tag, input int base, input logic [3:0] c,
                           input logic [1:0] r, input logic [1:0] p, input logic [7:0] d);
        chk(req_cnt == base + 1, {tag, " count"}, req_cnt - base, 1);
        chk(log_cmd[base] == c, {tag, " cmd"}, log_cmd[base], c);
        chk(log_reg[base] == r && log_pot[base] == p, {tag, " reg/pot"},
            {log_reg[base], log_pot[base]}, {r, p});
        chk(log_dat[base] == d, {tag, " data"}, log_dat[base], d);
    endtask

    // R10: idle outputs after reset.
    task automatic t_reset();
        chk(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
        chk(req_valid == 1'b0, "R10 req_valid", req_valid, 0);
    endtask

    // R4 and R1: three-byte writes to both register kinds.
    task automatic t_write();
        bit a0, a1, a2; int base;
        base = req_cnt;
        bus_start(); send_byte(8'h56, a0); send_byte(8'hA6, a1); send_byte(8'hA5, a2); bus_stop();
        chk(a0 && a1 && a2, "R1 R4 write acks", {a0, a1, a2}, 3'b111);
        chk_req("R4 write wiper", base, 4'd2, 2'd1, 2'd2, 8'hA5);
        base = req_cnt;
        bus_start(); send_byte(8'h56, a0); send_byte(8'hCC, a1); send_byte(8'h3C, a2); bus_stop();
        chk(a0 && a1 && a2, "R4 write dr acks", {a0, a1, a2}, 3'b111);
        chk_req("R4 write dr", base, 4'd4, 2'd3, 2'd0, 8'h3C);
        chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
    endtask

    // R5: reads return rd_data MSB first.
    task automatic t_read();
        bit a0, a1; logic [7:0] v; int base;
        rd_data = 8'hC3; base = req_cnt;
        bus_start(); send_byte(8'h56, a0); send_byte(8'hB9, a1); recv_byte(v, 1'b0);
        chk(sda_oe == 1'b0, "R5 released after byte", sda_oe, 0);
        bus_stop();
        chk(a0 && a1, "R5 read dr acks", {a0, a1}, 2'b11);
        chk(v == 8'hC3, "R5 read dr data", v, 8'hC3);
        chk_req("R5 read dr", base, 4'd3, 2'd2, 2'd1, 8'h00);
        rd_data = 8'h5A; base = req_cnt;
        bus_start(); send_byte(8'h56, a0); send_byte(8'h93, a1); recv_byte(v, 1'b0); bus_stop();
        chk(v == 8'h5A, "R5 read wiper data", v, 8'h5A);
        chk_req("R5 read wiper", base, 4'd1, 2'd0, 2'd3, 8'h00);
    endtask

    // R6: two-byte transfers, local and global.
    task automatic t_xfer();
        logic [3:0] ops [4] = '{4'b1101, 4'b1110, 4'b0001, 4'b1000};
        logic [3:0] cds [4] = '{4'd5, 4'd6, 4'd7, 4'd8};
        for (int k = 0; k < 4; k++) begin
            bit a0, a1; int base;
            base = req_cnt;
            bus_start(); send_byte(8'h56, a0);
            send_byte({ops[k], 2'(k), 2'(3 - k)}, a1); bus_stop();
            chk(a0 && a1, "R6 transfer acks", {a0, a1}, 2'b11);
            chk_req("R6 transfer", base, cds[k], 2'(k), 2'(3 - k), 8'h00);
        end
    endtask

    // R3: unsupported opcodes are refused.
    task automatic t_bad();
        logic [3:0] ops [3] = '{4'b0000, 4'b0011, 4'b1111};
        for (int k = 0; k < 3; k++) begin
            bit a0, a1, a2; int base;
            base = req_cnt;
            bus_start(); send_byte(8'h56, a0); send_byte({ops[k], 4'h5}, a1);
            send_byte(8'h77, a2); bus_stop();
            chk(a0 && !a1 && !a2, "R3 bad opcode nack", {a0, a1, a2}, 3'b100);
            chk(req_cnt == base, "R3 bad opcode no request", req_cnt - base, 0);
        end
    endtask

    // R1: wrong strap or wrong device type are ignored to the end of frame.
    task automatic t_mismatch();
        bit a0, a1, a2; int base;
        base = req_cnt;
        bus_start(); send_byte(8'h57, a0); send_byte(8'hA6, a1); send_byte(8'h11, a2); bus_stop();
        chk(!a0 && !a1 && !a2, "R1 strap mismatch nack", {a0, a1, a2}, 0);
        bus_start(); send_byte(8'h46, a0); send_byte(8'hD0, a1); bus_stop();
        chk(!a0 && !a1, "R1 type mismatch nack", {a0, a1}, 0);
        chk(req_cnt == base, "R1 mismatch no request", req_cnt - base, 0);
    endtask

    // R2: busy bank refuses the address.
    task automatic t_busy();
        bit a0, a1; int base;
        base = req_cnt; busy = 1'b1;
        bus_start(); send_byte(8'h56, a0); send_byte(8'hD5, a1); bus_stop();
        busy = 1'b0;
        chk(!a0 && !a1, "R2 busy nack", {a0, a1}, 0);
        chk(req_cnt == base, "R2 busy no request", req_cnt - base, 0);
    endtask

    // R7: stepping mode, direction from SDA, no step at STOP.
    task automatic t_step();
        bit a0, a1; int base;
        logic pat [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
        base = req_cnt;
        bus_start(); send_byte(8'h56, a0); send_byte(8'h29, a1);
        for (int k = 0; k < 5; k++) send_bit(pat[k]);
        bus_stop();
        chk(a0 && a1, "R7 step acks", {a0, a1}, 2'b11);
        chk(req_cnt == base + 5, "R7 step count", req_cnt - base, 5);
        for (int k = 0; k < 5; k++) begin
            logic [3:0] e;
            e = pat[k] ? 4'd9 : 4'd10;
            chk(log_cmd[base + k] == e, "R7 step direction", log_cmd[base + k], e);
            chk(log_reg[base + k] == 2'd2 && log_pot[base + k] == 2'd1, "R7 step target",
                {log_reg[base + k], log_pot[base + k]}, 4'b1001);
        end
    endtask

    // R8: repeated START mid-address and mid-instruction aborts the frame.
    task automatic t_restart();
        bit a0, a1, a2; int base;
        base = req_cnt;
        bus_start(); for (int k = 0; k < 5; k++) send_bit(1'b0);
        bus_start(); send_byte(8'h56, a0);
        for (int k = 0; k < 3; k++) send_bit(1'b1);
        chk(req_cnt == base, "R8 no request on abort", req_cnt - base, 0);
        bus_start(); send_byte(8'h56, a1); send_byte(8'hA4, a2);
        send_byte(8'h81, a0); bus_stop();
        chk(a1 && a2 && a0, "R8 frame after restart acks", {a1, a2, a0}, 3'b111);
        chk_req("R8 restart write", base, 4'd2, 2'd1, 2'd0, 8'h81);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_write();
        t_read();
        t_xfer();
        t_bad();
        t_mismatch();
        t_busy();
        t_step();
        t_restart();
        chk(pulse_err == 0, "R9 single-cycle request", pulse_err, 0);
        chk(oe_glitch == 0, "R11 drive changes only while SCL low", oe_glitch, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule